// File: doc/BRIEF.md
# Pinball Controller Bus Decoder with Switch Row Latch

This block sits between a 16-bit processor bus and the peripherals of a pinball controller board. It decodes the low 17 address bits into a program ROM select, a battery-backed RAM select and eight 2 KB I/O windows. Each window has a write strobe, and some also have a read strobe. Every output is registered, so each one appears one clock after the bus cycle that caused it. A cycle is qualified by `bus_valid`, and each valid cycle produces one single-cycle pulse.

The block also steers the switch matrix. A write to the lamp/row window drives one row of the matrix on its upper data byte. The block converts that one-hot row drive into a 3-bit row index and holds it. A later read of the key window returns the eight switch contacts of the held row on the low byte of `bus_rdata`. Two more read-only windows are handled inside the block: the retrigger input always reads as all ones, and the sound-feedback input always reads as zero. The memories, drivers and sound board are all outside the block.

Top module: `pfio_decoder`

## Requirements
- R1: Only address bits 16:0 are decoded. Bits 23:17 have no effect on any output.
- R2: A valid access to 0x00000–0x03FFF or 0x06000–0x0FFFF pulses `rom_sel`.
- R3: A valid access to 0x04000–0x04FFF pulses `ram_sel`.
- R4: A valid write to 0x14000 + k·0x800 (k = 0..7, each window 0x800 bytes) pulses bit k of `io_wr_stb`. The windows are: k=0 lamp/row, 1 lamp bank 2, 2 solenoid bank 1, 3 solenoid bank 2, 4 sound command, 5 display 1, 6 display 2, 7 auxiliary. At most one select or strobe output is high in any cycle.
- R5: A valid read pulses bit k of `io_rd_stb` only for k = 0 (key), 1 (sound feedback) and 2 (retrigger). A read of windows 3–7, including the solenoid-2 window 0x15800–0x15FFF, asserts no read strobe and returns zero.
- R6: A write to window 0 loads the row index with (position − 8) of the highest set bit among data bits 15:8.
- R7: A write to window 0 whose bits 15:8 are all zero leaves the row index unchanged.
- R8: A key-window read returns `{8'h00, sw_matrix[row*8 +: 8]}`, using the row index held at the time of the read. A write in one cycle steers a read in the next cycle.
- R9: A retrigger read returns 0xFFFF. A sound-feedback read, and every ROM or RAM read, returns zero.
- R10: An access to 0x05000–0x05FFF or 0x10000–0x13FFF asserts no output and returns zero.
- R11: Synchronous reset clears the row index to 0 and drives all outputs low.
- R12: Outputs follow a valid cycle by exactly one clock. A cycle without `bus_valid` leaves every select, strobe and `bus_rdata` low on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data |
| sw_matrix | input | 64 | Switch contacts, row r on bits r*8+7:r*8 |
| rom_sel | output | 1 | ROM select pulse |
| ram_sel | output | 1 | RAM select pulse |
| io_wr_stb | output | 8 | Per-window write strobes |
| io_rd_stb | output | 8 | Per-window read strobes |
| bus_rdata | output | 16 | Read data from block-sourced windows |
| row_sel | output | 3 | Held switch row index |

## Verification
A wrong row index inside the block cannot be seen directly on the bus. It shows up as the wrong switch byte on the first key read after the faulty update, one clock after that read. It also shows up at once on `row_sel`. The test pattern gives every row a distinct switch byte, so any stuck, off-by-one or lowest-bit-wins row encoding produces a visible mismatch. A bad region boundary or a bad window index shows up as a wrong or missing select bit in the cycle right after the access. The test vectors therefore probe the first and last word of every region and window.

// File: rtl/pfio_pkg.sv
package pfio_pkg;
  localparam int NUM_WIN   = 8;
  localparam int WIN_IDX_W = $clog2(NUM_WIN);

  // windows that have a read path inside or through the block
  localparam logic [NUM_WIN-1:0] RD_CAPABLE = 8'b0000_0111;
  localparam logic [WIN_IDX_W-1:0] WIN_KEY  = 3'd0;
  localparam logic [WIN_IDX_W-1:0] WIN_SFB  = 3'd1;
  localparam logic [WIN_IDX_W-1:0] WIN_RTRG = 3'd2;

  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_ROM,
    RGN_RAM,
    RGN_IO
  } region_e;

  typedef struct packed {
    region_e                rgn;
    logic [WIN_IDX_W-1:0]   win;
  } decode_t;
endpackage

// File: rtl/pfio_region_decode.sv
module pfio_region_decode
  import pfio_pkg::*;
#(
  parameter int DEC_W     = 17,
  parameter int WIN_LOG2  = 11,
  parameter logic [DEC_W-1:0] ROM0_END  = 17'h04000,
  parameter logic [DEC_W-1:0] RAM_BASE  = 17'h04000,
  parameter logic [DEC_W-1:0] RAM_END   = 17'h05000,
  parameter logic [DEC_W-1:0] ROM1_BASE = 17'h06000,
  parameter logic [DEC_W-1:0] ROM1_END  = 17'h10000,
  parameter logic [DEC_W-1:0] IO_BASE   = 17'h14000
) (
  input  logic [DEC_W-1:0] addr,
  output decode_t          dec
);
  localparam logic [DEC_W:0] IO_SPAN = (DEC_W+1)'(NUM_WIN) << WIN_LOG2;
  localparam logic [DEC_W:0] IO_END  = {1'b0, IO_BASE} + IO_SPAN;

  logic [DEC_W-1:0] io_off;
  logic             in_rom, in_ram, in_io;

  assign in_rom = (addr < ROM0_END) || (addr >= ROM1_BASE && addr < ROM1_END);
  assign in_ram = (addr >= RAM_BASE) && (addr < RAM_END);
  assign in_io  = (addr >= IO_BASE) && ({1'b0, addr} < IO_END);
  assign io_off = addr - IO_BASE;

  always_comb begin
    dec.win = io_off[WIN_LOG2 +: WIN_IDX_W];
    if (in_io)       dec.rgn = RGN_IO;
    else if (in_ram) dec.rgn = RGN_RAM;
    else if (in_rom) dec.rgn = RGN_ROM;
    else             dec.rgn = RGN_NONE;
  end
endmodule

// File: rtl/pfio_row_latch.sv
module pfio_row_latch #(
  parameter int ROWS  = 8,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ROWS-1:0]  drive,
  output logic [IDX_W-1:0] row
);
  logic [IDX_W-1:0] row_q, row_d;

  // highest driven row wins; an empty drive keeps the old row
  always_comb begin
    row_d = row_q;
    for (int i = 0; i < ROWS; i++)
      if (drive[i]) row_d = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst)       row_q <= '0;
    else if (load) row_q <= row_d;
  end

  assign row = row_q;

  // R7: blank drive leaves the row alone
  assert_hold_on_blank_R7: assert property (@(posedge clk) disable iff (rst)
    (load && drive == '0) |=> $stable(row));

  // R6: topmost driven line always selects the last row
  assert_top_line_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (load && drive[ROWS-1]) |=> (row == IDX_W'(ROWS-1)));
endmodule

// File: rtl/pfio_switch_mux.sv
module pfio_switch_mux #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic [IDX_W-1:0]     row,
  input  logic [ROWS*COLS-1:0] matrix,
  output logic [COLS-1:0]      contacts
);
  logic [COLS-1:0] rows_arr [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rows_arr[r] = matrix[r*COLS +: COLS];
  end

  assign contacts = rows_arr[row];
endmodule

// File: rtl/pfio_decoder.sv
module pfio_decoder
  import pfio_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int DEC_W     = 17,
  parameter int WIN_LOG2  = 11,
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int DRIVE_LSB = 8,
  localparam int IDX_W    = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [ROWS*COLS-1:0] sw_matrix,
  output logic                 rom_sel,
  output logic                 ram_sel,
  output logic [NUM_WIN-1:0]   io_wr_stb,
  output logic [NUM_WIN-1:0]   io_rd_stb,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [IDX_W-1:0]     row_sel
);
  decode_t           dec;
  logic              acc_rd, acc_wr, io_hit;
  logic [NUM_WIN-1:0] wr_d, rd_d;
  logic [DATA_W-1:0] rdata_d;
  logic [COLS-1:0]   contacts;
  logic              row_load;

  // address bits above the decoded span and the low write byte are not used
  logic unused_bits;
  assign unused_bits = ^{bus_addr[ADDR_W-1:DEC_W], bus_wdata[DRIVE_LSB-1:0]};

  pfio_region_decode #(.DEC_W(DEC_W), .WIN_LOG2(WIN_LOG2)) u_dec (
    .addr (bus_addr[DEC_W-1:0]),
    .dec  (dec)
  );

  assign acc_rd = bus_valid && !bus_write;
  assign acc_wr = bus_valid &&  bus_write;
  assign io_hit = (dec.rgn == RGN_IO);

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    assign wr_d[k] = acc_wr && io_hit && (dec.win == WIN_IDX_W'(k));
    if (RD_CAPABLE[k]) begin : g_rd
      assign rd_d[k] = acc_rd && io_hit && (dec.win == WIN_IDX_W'(k));
    end else begin : g_nord
      assign rd_d[k] = 1'b0;
    end
  end

  assign row_load = wr_d[WIN_KEY];

  pfio_row_latch #(.ROWS(ROWS)) u_row (
    .clk   (clk),
    .rst   (rst),
    .load  (row_load),
    .drive (bus_wdata[DRIVE_LSB +: ROWS]),
    .row   (row_sel)
  );

  pfio_switch_mux #(.ROWS(ROWS), .COLS(COLS)) u_mux (
    .row      (row_sel),
    .matrix   (sw_matrix),
    .contacts (contacts)
  );

  always_comb begin
    rdata_d = '0;
    if (rd_d[WIN_KEY])       rdata_d = {{(DATA_W-COLS){1'b0}}, contacts};
    else if (rd_d[WIN_RTRG]) rdata_d = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_sel   <= 1'b0;
      ram_sel   <= 1'b0;
      io_wr_stb <= '0;
      io_rd_stb <= '0;
      bus_rdata <= '0;
    end else begin
      rom_sel   <= bus_valid && (dec.rgn == RGN_ROM);
      ram_sel   <= bus_valid && (dec.rgn == RGN_RAM);
      io_wr_stb <= wr_d;
      io_rd_stb <= rd_d;
      bus_rdata <= rdata_d;
    end
  end

  // R12: an idle bus cycle leaves everything quiet next clock
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (!rom_sel && !ram_sel && io_wr_stb == '0 &&
                    io_rd_stb == '0 && bus_rdata == '0));

  // R4: never two targets at once
  assert_single_target_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_sel, ram_sel, io_wr_stb, io_rd_stb}));

  // R5: solenoid-2 window read produces no strobe and no data
  assert_sol2_read_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && bus_addr[16:11] == 6'h2B) |=> (io_rd_stb == '0 && bus_rdata == '0));

  // R9: retrigger window reads all ones
  assert_rtrg_ones_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && bus_addr[16:11] == 6'h2A) |=> (bus_rdata == '1));
endmodule

// File: tb/tb_pfio_decoder.sv
`timescale 1ns/1ps
module tb_pfio_decoder;
  typedef struct packed {
    logic        wr;
    logic [23:0] addr;
    logic [15:0] wdata;
    logic        rom;
    logic        ram;
    logic [7:0]  ws;
    logic [7:0]  rs;
    logic [15:0] rd;
    logic [2:0]  row;
  } vec_t;

  localparam int NV = 32;
  // switch row r reads {r, 15-r}
  localparam vec_t TBL [NV] = '{
    '{1'b0, 24'h000000, 16'h0, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd0}, // R2
    '{1'b0, 24'h003FFE, 16'h0, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd0}, // R2
    '{1'b0, 24'h004000, 16'h0, 1'b0, 1'b1, 8'h00, 8'h00, 16'h0000, 3'd0}, // R3
    '{1'b1, 24'h004FFE, 16'h0, 1'b0, 1'b1, 8'h00, 8'h00, 16'h0000, 3'd0}, // R3
    '{1'b0, 24'h005000, 16'h0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd0}, // R10
    '{1'b0, 24'h006000, 16'h0, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd0}, // R2
    '{1'b0, 24'h00FFFE, 16'h0, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd0}, // R2
    '{1'b0, 24'h010000, 16'h0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd0}, // R10
    '{1'b1, 24'h013FFE, 16'h0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd0}, // R10
    '{1'b0, 24'h020000, 16'h0, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd0}, // R1
    '{1'b1, 24'hFE4010, 16'h0, 1'b0, 1'b1, 8'h00, 8'h00, 16'h0000, 3'd0}, // R1
    '{1'b1, 24'h014000, 16'h0800, 1'b0, 1'b0, 8'h01, 8'h00, 16'h0000, 3'd3}, // R6
    '{1'b0, 24'h014002, 16'h0, 1'b0, 1'b0, 8'h00, 8'h01, 16'h003C, 3'd3}, // R8
    '{1'b1, 24'h014000, 16'hA500, 1'b0, 1'b0, 8'h01, 8'h00, 16'h0000, 3'd7}, // R6
    '{1'b0, 24'h0147FE, 16'h0, 1'b0, 1'b0, 8'h00, 8'h01, 16'h0078, 3'd7}, // R8
    '{1'b1, 24'h014000, 16'h00FF, 1'b0, 1'b0, 8'h01, 8'h00, 16'h0000, 3'd7}, // R7
    '{1'b0, 24'h014000, 16'h0, 1'b0, 1'b0, 8'h00, 8'h01, 16'h0078, 3'd7}, // R7
    '{1'b1, 24'h014800, 16'h0, 1'b0, 1'b0, 8'h02, 8'h00, 16'h0000, 3'd7}, // R4
    '{1'b0, 24'h014800, 16'h0, 1'b0, 1'b0, 8'h00, 8'h02, 16'h0000, 3'd7}, // R9
    '{1'b1, 24'h015000, 16'h0, 1'b0, 1'b0, 8'h04, 8'h00, 16'h0000, 3'd7}, // R4
    '{1'b0, 24'h0157FE, 16'h0, 1'b0, 1'b0, 8'h00, 8'h04, 16'hFFFF, 3'd7}, // R9
    '{1'b1, 24'h015800, 16'h0, 1'b0, 1'b0, 8'h08, 8'h00, 16'h0000, 3'd7}, // R4
    '{1'b0, 24'h015800, 16'h0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd7}, // R5
    '{1'b1, 24'h016000, 16'h0, 1'b0, 1'b0, 8'h10, 8'h00, 16'h0000, 3'd7}, // R4
    '{1'b1, 24'h016800, 16'h0, 1'b0, 1'b0, 8'h20, 8'h00, 16'h0000, 3'd7}, // R4
    '{1'b1, 24'h017000, 16'h0, 1'b0, 1'b0, 8'h40, 8'h00, 16'h0000, 3'd7}, // R4
    '{1'b1, 24'h017FFE, 16'h0, 1'b0, 1'b0, 8'h80, 8'h00, 16'h0000, 3'd7}, // R4
    '{1'b0, 24'h017800, 16'h0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd7}, // R5
    '{1'b1, 24'h014000, 16'h2000, 1'b0, 1'b0, 8'h01, 8'h00, 16'h0000, 3'd5}, // R6
    '{1'b0, 24'h014000, 16'h0, 1'b0, 1'b0, 8'h00, 8'h01, 16'h005A, 3'd5}, // R8
    '{1'b1, 24'h014000, 16'h0100, 1'b0, 1'b0, 8'h01, 8'h00, 16'h0000, 3'd0}, // R6
    '{1'b0, 24'h014000, 16'h0, 1'b0, 1'b0, 8'h00, 8'h01, 16'h000F, 3'd0}  // R8
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_write;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [63:0] sw_matrix;
  logic        rom_sel, ram_sel;
  logic [7:0]  io_wr_stb, io_rd_stb;
  logic [15:0] bus_rdata;
  logic [2:0]  row_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pfio_decoder dut (
    .clk, .rst, .bus_valid, .bus_write, .bus_addr, .bus_wdata, .sw_matrix,
    .rom_sel, .ram_sel, .io_wr_stb, .io_rd_stb, .bus_rdata, .row_sel
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input vec_t v);
    chk(req, "rom_sel", 32'(rom_sel), 32'(v.rom));
    chk(req, "ram_sel", 32'(ram_sel), 32'(v.ram));
    chk(req, "io_wr_stb", 32'(io_wr_stb), 32'(v.ws));
    chk(req, "io_rd_stb", 32'(io_rd_stb), 32'(v.rs));
    chk(req, "bus_rdata", 32'(bus_rdata), 32'(v.rd));
    chk(req, "row_sel", 32'(row_sel), 32'(v.row));
  endtask

  task automatic drive(input logic v, input logic w, input logic [23:0] a,
                       input logic [15:0] d);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) sw_matrix[r*8 +: 8] = {4'(r), 4'(15 - r)};
    rst = 1'b1;
    drive(1'b1, 1'b1, 24'h014000, 16'h8000);
    repeat (3) @(negedge clk);
    // R11: reset state even with a valid write held on the bus
    chk_all("R11", '{1'b0, 24'h0, 16'h0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd0});
    drive(1'b0, 1'b0, 24'h0, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    // table walk, one vector per cycle, back to back
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, TBL[i].wr, TBL[i].addr, TBL[i].wdata);
      @(negedge clk);
      chk_all($sformatf("vec%0d", i), TBL[i]);
    end

    // R12: strobe is a single pulse; an idle cycle with a window address stays quiet
    drive(1'b1, 1'b1, 24'h014000, 16'h4000);
    @(negedge clk);
    chk("R12", "wr strobe", 32'(io_wr_stb), 32'h01);
    chk("R6", "row", 32'(row_sel), 32'd6);
    drive(1'b0, 1'b0, 24'h015000, 16'h0);
    @(negedge clk);
    chk_all("R12", '{1'b0, 24'h0, 16'h0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0000, 3'd6});
    drive(1'b0, 1'b1, 24'h014000, 16'h8000);
    @(negedge clk);
    chk("R12", "row not loaded when idle", 32'(row_sel), 32'd6);

    // R8: switch change seen on next read of same row
    sw_matrix[6*8 +: 8] = 8'hC3;
    drive(1'b1, 1'b0, 24'h014000, 16'h0);
    @(negedge clk);
    chk("R8", "key read", 32'(bus_rdata), 32'h00C3);

    // R1: high bits set on a window address
    drive(1'b1, 1'b0, 24'hFF5000, 16'h0);
    @(negedge clk);
    chk("R1", "rtrg via aliased addr", 32'(bus_rdata), 32'hFFFF);
    chk("R1", "rd strobe", 32'(io_rd_stb), 32'h04);

    // R11: reset mid-run clears the row
    rst = 1'b1;
    drive(1'b0, 1'b0, 24'h0, 16'h0);
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "row after reset", 32'(row_sel), 32'd0);
    chk("R11", "rdata after reset", 32'(bus_rdata), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule